// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This block is a processor-side interval timer. A free-running count register moves up by one on every count-enable tick (nominally a 100 MHz strobe). A compare register is held beside it. When the two are equal while counting is enabled, a timer interrupt becomes pending. It stays pending until software writes the compare register, which is the only way to acknowledge it.

The pending interrupt is steered onto one of eight request lines, chosen by a 3-bit select input that can change at any time. A separate status bit mirrors the pending interrupt, but only when the release-2 feature input is high; otherwise it reads 0. A freeze input stops the count for debug or power states. While frozen, the count can still be loaded directly, and no new interrupt can be raised. Bus decode and the interrupt controller sit outside this block. The block only sees write strobes with a shared data word, and it drives the request vector.

Top module: `tick_match_timer`

## Requirements
- R1: When reset is released, the count reads 1, the compare register holds 0, every interrupt line is low and the status bit is 0.
- R2: On each clock with the tick high, the freeze input low and no count write, the count rises by exactly one. It wraps from 0xFFFFFFFF to 0, and the wrap on its own raises no interrupt.
- R3: A count write loads the write data on the next clock. It takes priority over a tick in the same cycle, and it still works while the freeze input is high.
- R4: While the freeze input is high, ticks leave the count unchanged, and an equal count and compare raises no interrupt.
- R5: If the count equals the compare register while the freeze input is low, the interrupt is pending from the next clock edge.
- R6: The request vector has bit k high, where k is the value on the 3-bit select input, exactly when an interrupt is pending. All other bits are low. A change of select moves the request in the same cycle, with no clock edge needed.
- R7: With the release-2 input high, the status bit equals the pending interrupt. With it low, the status bit is 0.
- R8: A pending interrupt stays pending when the count moves past the compare value, until the compare register is written.
- R9: A compare write loads the compare register and clears the pending interrupt on the next clock. It wins over a match in the same cycle. If count and compare are still equal afterwards, the interrupt is pending again one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Count-enable strobe |
| cnt_wr_i | input | 1 | Write strobe for the count register |
| cmp_wr_i | input | 1 | Write strobe for the compare register; acknowledges the interrupt |
| wr_data_i | input | 32 | Write data shared by both strobes |
| freeze_i | input | 1 | Holds the count and blocks new interrupts |
| rev2_i | input | 1 | Enables the timer status bit |
| line_sel_i | input | 3 | Index of the request line used for the interrupt |
| count_o | output | 32 | Current count |
| tstat_o | output | 1 | Timer interrupt status |
| irq_o | output | 8 | Interrupt request vector |

## Verification
The bench tracks a cycle-level model built from the requirements and compares all outputs after every clock. It sweeps match offsets against every select line and both release-2 settings. If the match cycle is off by one, the request rises a clock early or late in that sweep. If the design triggered on crossing rather than on equality, or let the request drop, the check that ticks well past the compare value catches it. The corner cases are targeted directly: a count write on the same cycle as a tick, a match while frozen, a compare write landing on the cycle of a match, a wrap through zero with compare parked elsewhere, and a select change with no clock edge. A design with the wrong priority, a stray interrupt on freeze or wrap, or a registered line select shows a wrong count or a wrong request bit in those cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned TMR_WIDTH     = 32;
  localparam int unsigned TMR_LINES     = 8;
  localparam int unsigned TMR_CNT_RESET = 1;
  localparam int unsigned TMR_CMP_RESET = 0;
  localparam int unsigned TMR_SYNC_STG  = 2;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int unsigned STAGES = tmr_pkg::TMR_SYNC_STG
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W       = tmr_pkg::TMR_WIDTH,
  parameter int unsigned RST_VAL = tmr_pkg::TMR_CNT_RESET
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         freeze_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_data_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;
  logic         step;

  // a load beats a tick; freeze only stops stepping
  always_comb begin
    step   = tick_i && !freeze_i;
    cnt_en = ld_i || step;
    if (ld_i) cnt_d = ld_data_i;
    else      cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= W'(RST_VAL);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int unsigned W       = tmr_pkg::TMR_WIDTH,
  parameter int unsigned RST_VAL = tmr_pkg::TMR_CMP_RESET
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] count_i,
  input  logic         freeze_i,
  input  logic         cmp_wr_i,
  input  logic [W-1:0] cmp_data_i,
  output logic [W-1:0] cmp_o,
  output logic         pend_o
);
  logic [W-1:0] cmp_q;
  logic         pend_q;
  logic         pend_d;
  logic         pend_en;
  logic         hit;

  always_comb begin
    hit     = (count_i == cmp_q) && !freeze_i;
    pend_en = cmp_wr_i || hit;
    // acknowledge has priority over a match in the same cycle
    pend_d  = !cmp_wr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmp_q <= W'(RST_VAL);
    else if (cmp_wr_i) cmp_q <= cmp_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign cmp_o  = cmp_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/tmr_route.sv
module tmr_route #(
  parameter int unsigned LINES = tmr_pkg::TMR_LINES,
  parameter int unsigned SEL_W = $clog2(LINES)
) (
  input  logic             pend_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [LINES-1:0] irq_o
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign irq_o[i] = pend_i && (sel_i == SEL_W'(i));
  end
endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer #(
  parameter int unsigned W     = tmr_pkg::TMR_WIDTH,
  parameter int unsigned LINES = tmr_pkg::TMR_LINES,
  localparam int unsigned SEL_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cnt_wr_i,
  input  logic             cmp_wr_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic             freeze_i,
  input  logic             rev2_i,
  input  logic [SEL_W-1:0] line_sel_i,
  output logic [W-1:0]     count_o,
  output logic             tstat_o,
  output logic [LINES-1:0] irq_o
);
  logic         rst_sync_n;
  logic [W-1:0] cnt_w;
  logic [W-1:0] cmp_q;
  logic         pend;

  tmr_rst_sync #(.STAGES(tmr_pkg::TMR_SYNC_STG)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  tmr_counter #(.W(W), .RST_VAL(tmr_pkg::TMR_CNT_RESET)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .tick_i    (tick_i),
    .freeze_i  (freeze_i),
    .ld_i      (cnt_wr_i),
    .ld_data_i (wr_data_i),
    .count_o   (cnt_w)
  );

  tmr_match #(.W(W), .RST_VAL(tmr_pkg::TMR_CMP_RESET)) u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .count_i    (cnt_w),
    .freeze_i   (freeze_i),
    .cmp_wr_i   (cmp_wr_i),
    .cmp_data_i (wr_data_i),
    .cmp_o      (cmp_q),
    .pend_o     (pend)
  );

  tmr_route #(.LINES(LINES), .SEL_W(SEL_W)) u_route (
    .pend_i (pend),
    .sel_i  (line_sel_i),
    .irq_o  (irq_o)
  );

  assign count_o = cnt_w;
  assign tstat_o = pend && rev2_i;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned W     = 32,
  parameter int unsigned LINES = 8
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             tick_i,
  input logic             freeze_i,
  input logic             cnt_wr_i,
  input logic             cmp_wr_i,
  input logic [W-1:0]     wr_data_i,
  input logic [W-1:0]     count_o,
  input logic [W-1:0]     cmp_q,
  input logic             tstat_o,
  input logic [LINES-1:0] irq_o
);
  AST_TICK_STEP: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tick_i && !freeze_i && !cnt_wr_i) |=> (count_o == $past(count_o) + W'(1))); // R2

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_n)
    cnt_wr_i |=> (count_o == $past(wr_data_i))); // R3

  AST_FROZEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (freeze_i && !cnt_wr_i) |=> $stable(count_o)); // R4

  AST_HIT_RAISE: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((count_o == cmp_q) && !freeze_i && !cmp_wr_i) |=> (irq_o != '0)); // R5

  AST_ONE_LINE: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(irq_o)); // R6

  AST_STAT_PAIR: assert property (@(posedge clk_i) disable iff (!rst_n)
    tstat_o |-> (irq_o != '0)); // R7

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((irq_o != '0) && !cmp_wr_i) |=> (irq_o != '0)); // R8

  AST_ACK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_n)
    cmp_wr_i |=> ((irq_o == '0) && !tstat_o && (cmp_q == $past(wr_data_i)))); // R9
endmodule

bind tick_match_timer tmr_checker #(.W(W), .LINES(LINES)) chk_i (
  .clk_i     (clk_i),
  .rst_n     (rst_sync_n),
  .tick_i    (tick_i),
  .freeze_i  (freeze_i),
  .cnt_wr_i  (cnt_wr_i),
  .cmp_wr_i  (cmp_wr_i),
  .wr_data_i (wr_data_i),
  .count_o   (count_o),
  .cmp_q     (cmp_q),
  .tstat_o   (tstat_o),
  .irq_o     (irq_o)
);

// File: tb/tick_match_timer_tb_top.sv
module tick_match_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 32;
  localparam int LN = 8;
  localparam int SW = 3;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst_n, tick, cnt_wr, cmp_wr, freeze, rev2;
  logic [W-1:0]  wdata;
  logic [SW-1:0] sel;
  logic [W-1:0]  count;
  logic          tstat;
  logic [LN-1:0] irq;

  tick_match_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cnt_wr_i(cnt_wr),
    .cmp_wr_i(cmp_wr), .wr_data_i(wdata), .freeze_i(freeze), .rev2_i(rev2),
    .line_sel_i(sel), .count_o(count), .tstat_o(tstat), .irq_o(irq)
  );

  int total = 0;
  int bad   = 0;
  logic [W-1:0] m_cnt, m_cmp;
  logic         m_pend;

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [LN-1:0] exp_irq();
    return m_pend ? (LN'(1) << sel) : '0;
  endfunction

  task automatic check_outs(string tag);
    chk(tag, "count", count, m_cnt);
    chk(tag, "irq", W'(irq), W'(exp_irq()));
    chk(tag, "tstat", W'(tstat), W'(m_pend && rev2));
  endtask

  task automatic quiet();
    tick = 1'b0; cnt_wr = 1'b0; cmp_wr = 1'b0;
  endtask

  // one clock: model next state from the requirements, then compare
  task automatic step(string tag);
    logic hit;
    logic [W-1:0] n_cnt, n_cmp;
    logic n_pend;
    hit    = (m_cnt == m_cmp) && !freeze;
    n_pend = cmp_wr ? 1'b0 : (hit ? 1'b1 : m_pend);
    n_cnt  = cnt_wr ? wdata : ((tick && !freeze) ? m_cnt + 1 : m_cnt);
    n_cmp  = cmp_wr ? wdata : m_cmp;
    @(posedge clk);
    #1;
    m_cnt = n_cnt; m_cmp = n_cmp; m_pend = n_pend;
    check_outs(tag);
  endtask

  task automatic wr_cmp(string tag, logic [W-1:0] v);
    quiet(); cmp_wr = 1'b1; wdata = v; step(tag); quiet();
  endtask

  task automatic wr_cnt(string tag, logic [W-1:0] v);
    quiet(); cnt_wr = 1'b1; wdata = v; step(tag); quiet();
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; quiet(); freeze = 1'b0; rev2 = 1'b1; sel = '0; wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    m_cnt = 1; m_cmp = 0; m_pend = 1'b0;
    // R1: reset values
    check_outs("R1");
    chk("R1", "count reset", count, 32'd1);

    // R2: plain ticking from the reset value
    tick = 1'b1;
    for (int i = 0; i < 20; i++) step("R2");
    chk("R2", "count after 20 ticks", count, 32'd21);
    quiet();

    // R1: compare resets to 0 -> load 0 while frozen, then unfreeze
    freeze = 1'b1;
    wr_cnt("R1", '0);
    step("R1");
    freeze = 1'b0;
    step("R1");
    chk("R1", "irq from compare reset 0", W'(irq), W'(1));
    wr_cmp("R9", 32'd5);

    // R2: wrap through zero with compare elsewhere
    wr_cnt("R2", 32'hFFFF_FFFE);
    tick = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step("R2");
      if (i == 1) chk("R2", "wrap to zero", count, '0);
    end
    chk("R2", "no irq after wrap", W'(irq), '0);
    quiet();

    // R3: write beats a tick; write while frozen
    tick = 1'b1; cnt_wr = 1'b1; wdata = 32'd1000;
    step("R3");
    chk("R3", "write wins over tick", count, 32'd1000);
    freeze = 1'b1; wdata = 32'd2000;
    step("R3");
    chk("R3", "write while frozen", count, 32'd2000);
    quiet();

    // R4: frozen with equal compare: no count change, no interrupt
    wr_cmp("R4", 32'd2000);
    tick = 1'b1;
    for (int i = 0; i < 5; i++) step("R4");
    chk("R4", "frozen hold", count, 32'd2000);
    chk("R4", "no irq frozen", W'(irq), '0);

    // R5: unfreeze -> pending on next edge
    tick = 1'b0; freeze = 1'b0;
    step("R5");
    chk("R5", "irq after unfreeze", W'(irq), W'(1));

    // R8: ticks past compare keep it pending
    tick = 1'b1;
    for (int i = 0; i < 6; i++) step("R8");
    chk("R8", "sticky irq", W'(irq), W'(1));
    quiet();

    // R9: compare write acknowledges
    wr_cmp("R9", 32'h10);
    chk("R9", "ack clears", W'(irq), '0);

    // R5 R6 R7: match offset sweep over every line and both rev2 settings
    for (int off = 0; off < 16; off++) begin
      rev2 = off[0];
      sel  = SW'(off % LN);
      wr_cmp("R5", 32'h100 + W'(off));
      wr_cnt("R5", 32'h100);
      tick = 1'b1;
      for (int k = 0; k < off + 3; k++) step("R5");
      chk("R6", "swept line", W'(irq), W'(LN'(1) << sel));
      chk("R7", "swept status", W'(tstat), W'(rev2));
      quiet();
      wr_cmp("R9", '0);
    end

    // R9: compare write on the cycle of a match, then re-arm
    rev2 = 1'b1; sel = '0;
    wr_cnt("R9", 32'h40);
    wr_cmp("R9", 32'h40);
    step("R9");
    chk("R9", "pending at equal", W'(irq), W'(1));
    cmp_wr = 1'b1; wdata = 32'h40;
    step("R9");
    chk("R9", "write wins over match", W'(irq), '0);
    quiet();
    step("R9");
    chk("R9", "re-armed", W'(irq), W'(1));

    // R6: select moves with no clock edge
    for (int s = 0; s < LN; s++) begin
      sel = SW'(s);
      #1;
      chk("R6", "line move", W'(irq), W'(LN'(1) << s));
    end

    // R7: status follows release-2 input
    rev2 = 1'b0; #1;
    chk("R7", "status off", W'(tstat), '0);
    rev2 = 1'b1; #1;
    chk("R7", "status on", W'(tstat), W'(1));
    step("R7");

    summary();
    $finish;
  end
endmodule